// File: doc/BRIEF.md
# Multichannel TDC Hit Readout Controller

This block gathers timestamped hits from up to sixteen time-to-digital converter channels and sends them, one 16-bit word at a time, over a single shared output bus. Every channel carries a qualifier that admits one hit and then shuts the channel for a fixed dead-time window. An admitted hit is stamped with the shared coarse time and the channel's own fine code, then written into that channel's event buffer. The coarse time arrives from two Gray-coded counters: one is the working copy and the other is a redundant copy used to detect single-event upsets.

A scanner walks the channels in a fixed cyclic order. At the first non-empty buffer it finds, it pulls one event and emits it as a two-word burst: a header word carrying the channel number, and then the binary coarse time. Output words are pushed without any request from downstream. They go out on a slot grid that allows at most one word per `OUT_DIV` clock cycles. The default of 4 gives 20 MHz output slots from an 80 MHz scan clock.

A test mode skips the buffers: an admitted hit shows up on the output bus as a single header word on the very next clock. Each channel keeps a saturating count of hits it had to drop because its buffer was full.

Top module: `tdc_hit_readout`

## Requirements
- R1: After reset, `out_valid` is 0 and every field of `ovf_count` is 0.
- R2: A channel that accepts a hit in cycle t ignores hits in cycles t+1 through t+DEAD_CYC. A hit in cycle t+DEAD_CYC+1 is accepted again.
- R3: Each buffered event leaves as two words. The header word has bits [15:12] = channel number, bit 11 = Gray error flag, bits [10:8] = 0 and bits [7:0] = fine code. The data word is the binary value of the primary Gray coarse code sampled with the hit.
- R4: The two words of one event are emitted exactly OUT_DIV cycles apart, with no other word between them.
- R5: In normal mode, consecutive `out_valid` pulses are at least OUT_DIV cycles apart.
- R6: The scanner serves pending channels in increasing index order, wrapping from the last channel back to channel 0. Events from one channel leave in the order they were accepted.
- R7: A channel buffer holds up to EVT_DEPTH events. A hit accepted while the buffer is full is dropped, and that channel's counter in `ovf_count` (field c at bits [c*OVF_W +: OVF_W]) rises by one, saturating at 2^OVF_W-1.
- R8: Header bit 11 is set when the primary and redundant Gray coarse inputs differ in the cycle the hit is accepted, and is clear when they match.
- R9: With `test_mode` high, an accepted hit is not written to any buffer. On the next clock `out_valid` rises for exactly one cycle, carrying the header-format word of the lowest-numbered channel that accepted a hit in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 1 | Buffer bypass mode select |
| hit_in | input | NUM_CH | Per-channel hit strobes |
| fine_in | input | NUM_CH*8 | Per-channel fine time codes, channel c at [c*8 +: 8] |
| coarse_gray_a | input | 16 | Primary Gray-coded coarse time |
| coarse_gray_b | input | 16 | Redundant Gray-coded coarse time |
| out_valid | output | 1 | Output word strobe |
| out_word | output | 16 | Output data word |
| ovf_count | output | NUM_CH*OVF_W | Per-channel saturating dropped-hit counters |

## Verification
The assertions rely on two assumptions about the inputs:
- `test_mode` changes only while the scanner is idle and no burst is in flight.
- The coarse inputs are stable in any cycle that carries a hit.

The stimulus meets both. It toggles test mode only after long drain waits with every buffer empty, and it holds both Gray inputs constant for the whole of each hit pulse. Hit strobes are driven on the falling clock edge, so every hit is seen at exactly one rising edge.

// File: rtl/tdc_ro_pkg.sv
package tdc_ro_pkg;

    localparam int WORD_W    = 16;
    localparam int FINE_W    = 8;
    localparam int COARSE_W  = 16;
    localparam int EVT_WORDS = 2;
    localparam int WIDX_W    = (EVT_WORDS > 1) ? $clog2(EVT_WORDS) : 1;

    typedef struct packed {
        logic                err;
        logic [FINE_W-1:0]   fine;
        logic [COARSE_W-1:0] coarse;
    } evt_t;

    function automatic logic [COARSE_W-1:0] gray_to_bin(input logic [COARSE_W-1:0] g);
        logic [COARSE_W-1:0] b;
        b[COARSE_W-1] = g[COARSE_W-1];
        for (int i = COARSE_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/tdc_ro_channel.sv
module tdc_ro_channel
    import tdc_ro_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int DEAD_CYC = 4,
    parameter int OVF_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  evt_t             evt_i,
    input  logic             bypass_i,
    input  logic             pop_i,
    output logic             accept_o,
    output logic             empty_o,
    output evt_t             head_o,
    output logic [OVF_W-1:0] ovf_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int DT_W  = $clog2(DEAD_CYC + 1);

    typedef struct packed {
        logic [DEPTH-1:0][$bits(evt_t)-1:0] mem;
        logic [PTR_W-1:0]                   wr;
        logic [PTR_W-1:0]                   rd;
        logic [CNT_W-1:0]                   cnt;
        logic [DT_W-1:0]                    dead;
        logic [OVF_W-1:0]                   ovf;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      full, push, drop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        accept_o = hit_i && (st_q.dead == '0);
        full     = (st_q.cnt == CNT_W'(DEPTH));
        push     = accept_o && !bypass_i && !full;
        drop     = accept_o && !bypass_i && full;

        if (accept_o) begin
            st_d.dead = DT_W'(DEAD_CYC);
        end else if (st_q.dead != '0) begin
            st_d.dead = st_q.dead - 1'b1;
        end

        if (push) begin
            st_d.mem[st_q.wr] = evt_i;
            st_d.wr           = ptr_next(st_q.wr);
        end
        if (pop_i) begin
            st_d.rd = ptr_next(st_q.rd);
        end
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop_i);

        if (drop && (st_q.ovf != {OVF_W{1'b1}})) begin
            st_d.ovf = st_q.ovf + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign empty_o = (st_q.cnt == '0);
    assign head_o  = evt_t'(st_q.mem[st_q.rd]);
    assign ovf_o   = st_q.ovf;

    // R2
    dead_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !accept_o);

    // R7
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R7
    ovf_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (st_q.ovf >= $past(st_q.ovf)));

    // R6
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

endmodule

// File: rtl/tdc_ro_scanner.sv
module tdc_ro_scanner
    import tdc_ro_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int OUT_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_i,
    input  logic              tm_valid_i,
    input  logic [WORD_W-1:0] tm_word_i,
    input  logic [NUM_CH-1:0] empty_i,
    input  evt_t              heads_i [NUM_CH],
    output logic [NUM_CH-1:0] pop_o,
    output logic              out_valid_o,
    output logic [WORD_W-1:0] out_word_o
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int SL_W  = (OUT_DIV > 1) ? $clog2(OUT_DIV) : 1;
    localparam int GAP_W = $clog2(OUT_DIV + 1);

    typedef struct packed {
        logic [IDX_W-1:0]  ptr;
        logic              busy;
        logic [IDX_W-1:0]  ch;
        evt_t              evt;
        logic [WIDX_W-1:0] widx;
        logic [SL_W-1:0]   slot;
        logic              ov;
        logic              tm;
        logic [WORD_W-1:0] ow;
        logic [GAP_W-1:0]  gap;
    } sc_state_t;

    sc_state_t sc_d, sc_q;

    function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(NUM_CH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        sc_d  = sc_q;
        pop_o = '0;
        sc_d.ov = 1'b0;
        sc_d.tm = 1'b0;
        sc_d.slot = (sc_q.slot == SL_W'(OUT_DIV - 1)) ? '0 : sc_q.slot + 1'b1;

        if (test_i) begin
            sc_d.ov = tm_valid_i;
            sc_d.tm = tm_valid_i;
            sc_d.ow = tm_word_i;
        end else if (!sc_q.busy) begin
            if (!empty_i[sc_q.ptr]) begin
                pop_o[sc_q.ptr] = 1'b1;
                sc_d.busy = 1'b1;
                sc_d.ch   = sc_q.ptr;
                sc_d.evt  = heads_i[sc_q.ptr];
                sc_d.widx = '0;
            end else begin
                sc_d.ptr = idx_next(sc_q.ptr);
            end
        end else if (sc_q.slot == '0) begin
            sc_d.ov = 1'b1;
            if (sc_q.widx == '0) begin
                sc_d.ow = {4'(sc_q.ch), sc_q.evt.err, 3'b000, sc_q.evt.fine};
            end else begin
                sc_d.ow = sc_q.evt.coarse;
            end
            if (sc_q.widx == WIDX_W'(EVT_WORDS - 1)) begin
                sc_d.busy = 1'b0;
                sc_d.ptr  = idx_next(sc_q.ptr);
            end else begin
                sc_d.widx = sc_q.widx + 1'b1;
            end
        end

        if (sc_q.ov && !sc_q.tm) begin
            sc_d.gap = GAP_W'(1);
        end else if (sc_q.gap != GAP_W'(OUT_DIV)) begin
            sc_d.gap = sc_q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_q     <= '0;
            sc_q.gap <= GAP_W'(OUT_DIV);
        end else begin
            sc_q <= sc_d;
        end
    end

    assign out_valid_o = sc_q.ov;
    assign out_word_o  = sc_q.ow;

    // R5
    out_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_q.ov && !sc_q.tm) |-> (sc_q.gap >= GAP_W'(OUT_DIV)));

    // R6
    single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop_o));

    // R6
    pop_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_o & empty_i) == '0);

    // R9
    test_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_i |-> (pop_o == '0));

endmodule

// File: rtl/tdc_hit_readout.sv
module tdc_hit_readout
    import tdc_ro_pkg::*;
#(
    parameter int NUM_CH    = 16,
    parameter int EVT_DEPTH = 16,
    parameter int DEAD_CYC  = 4,
    parameter int OUT_DIV   = 4,
    parameter int OVF_W     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      test_mode,
    input  logic [NUM_CH-1:0]         hit_in,
    input  logic [NUM_CH*FINE_W-1:0]  fine_in,
    input  logic [COARSE_W-1:0]       coarse_gray_a,
    input  logic [COARSE_W-1:0]       coarse_gray_b,
    output logic                      out_valid,
    output logic [WORD_W-1:0]         out_word,
    output logic [NUM_CH*OVF_W-1:0]   ovf_count
);

    logic [NUM_CH-1:0]  accept, empty, pop;
    evt_t               heads [NUM_CH];
    logic               gray_err;
    logic [COARSE_W-1:0] coarse_bin;
    logic               tm_valid;
    logic [WORD_W-1:0]  tm_word;

    assign gray_err   = (coarse_gray_a != coarse_gray_b);
    assign coarse_bin = gray_to_bin(coarse_gray_a);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        evt_t evt_in;
        assign evt_in = '{err: gray_err, fine: fine_in[c*FINE_W +: FINE_W], coarse: coarse_bin};

        tdc_ro_channel #(
            .DEPTH    (EVT_DEPTH),
            .DEAD_CYC (DEAD_CYC),
            .OVF_W    (OVF_W)
        ) i_channel (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit_i    (hit_in[c]),
            .evt_i    (evt_in),
            .bypass_i (test_mode),
            .pop_i    (pop[c]),
            .accept_o (accept[c]),
            .empty_o  (empty[c]),
            .head_o   (heads[c]),
            .ovf_o    (ovf_count[c*OVF_W +: OVF_W])
        );
    end

    always_comb begin
        tm_valid = 1'b0;
        tm_word  = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (accept[i]) begin
                tm_valid = 1'b1;
                tm_word  = {4'(i), gray_err, 3'b000, fine_in[i*FINE_W +: FINE_W]};
            end
        end
    end

    tdc_ro_scanner #(
        .NUM_CH  (NUM_CH),
        .OUT_DIV (OUT_DIV)
    ) i_scanner (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_i      (test_mode),
        .tm_valid_i  (tm_valid),
        .tm_word_i   (tm_word),
        .empty_i     (empty),
        .heads_i     (heads),
        .pop_o       (pop),
        .out_valid_o (out_valid),
        .out_word_o  (out_word)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !out_valid);

    // R9
    test_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && $past(test_mode) && $past(tm_valid)) |-> out_valid);

endmodule

// File: tb/test_tdc_hit_readout.sv
module test_tdc_hit_readout;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int DIV = 4;
    localparam int OW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              test_mode = 1'b0;
    logic [NCH-1:0]    hit_in = '0;
    logic [NCH*8-1:0]  fine_in = '0;
    logic [15:0]       coarse_gray_a = '0;
    logic [15:0]       coarse_gray_b = '0;
    logic              out_valid;
    logic [15:0]       out_word;
    logic [NCH*OW-1:0] ovf_count;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    logic [15:0] wq[$];
    int          tq[$];

    tdc_hit_readout i_tdc_hit_readout (
        .clk           (clk),
        .rst_n         (rst_n),
        .test_mode     (test_mode),
        .hit_in        (hit_in),
        .fine_in       (fine_in),
        .coarse_gray_a (coarse_gray_a),
        .coarse_gray_b (coarse_gray_b),
        .out_valid     (out_valid),
        .out_word      (out_word),
        .ovf_count     (ovf_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            wq.push_back(out_word);
            tq.push_back(cyc);
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] to_gray(input logic [15:0] b);
        return b ^ (b >> 1);
    endfunction

    task automatic set_coarse(input logic [15:0] bin, input logic [15:0] flip);
        coarse_gray_a = to_gray(bin);
        coarse_gray_b = to_gray(bin) ^ flip;
    endtask

    task automatic pulse(input logic [NCH-1:0] mask);
        @(negedge clk);
        hit_in = mask;
        @(negedge clk);
        hit_in = '0;
    endtask

    task automatic clear_q();
        wq.delete();
        tq.delete();
    endtask

    task automatic check_bursts(input string req);
        bit ok = (wq.size() % 2 == 0);
        for (int k = 1; k < wq.size(); k++) begin
            if ((k % 2) == 1 && (tq[k] - tq[k-1]) != DIV) ok = 0;
            if ((tq[k] - tq[k-1]) < DIV) ok = 0;
        end
        chk(ok, req, wq.size(), wq.size());
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(ovf_count == '0, "R1 ovf_count", ovf_count, 0);
    endtask

    task automatic t_format();
        clear_q();
        set_coarse(16'h1234, 16'h0);
        fine_in[6*8 +: 8] = 8'h5A;
        pulse(16'h0040);
        repeat (60) @(negedge clk);
        chk(wq.size() == 2, "R3 word count", wq.size(), 2);
        if (wq.size() == 2) begin
            chk(wq[0] == 16'h605A, "R3 header", wq[0], 16'h605A);
            chk(wq[1] == 16'h1234, "R3 coarse", wq[1], 16'h1234);
            chk(tq[1] - tq[0] == DIV, "R4 burst spacing", tq[1] - tq[0], DIV);
        end
    endtask

    task automatic t_gray();
        clear_q();
        set_coarse(16'h00FF, 16'h0001);
        fine_in[0 +: 8] = 8'h11;
        pulse(16'h0001);
        repeat (60) @(negedge clk);
        chk(wq.size() == 2, "R8 word count", wq.size(), 2);
        if (wq.size() == 2) begin
            chk(wq[0] == 16'h0811, "R8 error flag", wq[0], 16'h0811);
            chk(wq[1] == 16'h00FF, "R8 primary coarse", wq[1], 16'h00FF);
        end
    endtask

    task automatic t_dead();
        clear_q();
        set_coarse(16'h0042, 16'h0);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            hit_in = 16'h0002;
            fine_in[1*8 +: 8] = 8'(k);
        end
        @(negedge clk);
        hit_in = '0;
        repeat (80) @(negedge clk);
        chk(wq.size() == 4, "R2 accepted events", wq.size(), 4);
        if (wq.size() == 4) begin
            chk(wq[0] == 16'h1001, "R2 first hit", wq[0], 16'h1001);
            chk(wq[2] == 16'h1006, "R2 hit after window", wq[2], 16'h1006);
        end
    endtask

    task automatic t_order();
        int c0, c1, c2, desc;
        logic [7:0] f3[$];
        clear_q();
        set_coarse(16'h0007, 16'h0);
        fine_in[2*8 +: 8] = 8'h22;
        fine_in[5*8 +: 8] = 8'h25;
        fine_in[9*8 +: 8] = 8'h29;
        pulse(16'h0224);
        repeat (80) @(negedge clk);
        chk(wq.size() == 6, "R6 three events", wq.size(), 6);
        check_bursts("R4 R5 burst timing (multi)");
        if (wq.size() == 6) begin
            c0 = int'(wq[0][15:12]); c1 = int'(wq[2][15:12]); c2 = int'(wq[4][15:12]);
            desc = int'(c0 > c1) + int'(c1 > c2) + int'(c2 > c0);
            chk(desc == 1, "R6 cyclic order", {c0, c1, c2}, 32'h0);
        end
        clear_q();
        fine_in[3*8 +: 8] = 8'h31;
        fine_in[7*8 +: 8] = 8'h77;
        pulse(16'h0008);
        repeat (2) @(negedge clk);
        pulse(16'h0080);
        repeat (3) @(negedge clk);
        fine_in[3*8 +: 8] = 8'h32;
        pulse(16'h0008);
        repeat (80) @(negedge clk);
        for (int k = 0; k < wq.size(); k += 2) begin
            if (wq[k][15:12] == 4'd3) f3.push_back(wq[k][7:0]);
        end
        chk(f3.size() == 2, "R6 same-channel events", f3.size(), 2);
        if (f3.size() == 2) begin
            chk(f3[0] == 8'h31 && f3[1] == 8'h32, "R6 fifo order", {f3[0], f3[1]}, 16'h3132);
        end
    endtask

    task automatic t_test();
        clear_q();
        test_mode = 1'b1;
        set_coarse(16'h0003, 16'h0);
        fine_in[4*8 +: 8]  = 8'h44;
        fine_in[10*8 +: 8] = 8'hAA;
        repeat (2) @(negedge clk);
        hit_in = 16'h0410;
        @(negedge clk);
        chk(out_valid == 1'b1 && out_word == 16'h4044, "R9 bypass word", {out_valid, out_word}, 17'h14044);
        hit_in = '0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 single pulse", out_valid, 0);
        test_mode = 1'b0;
        clear_q();
        repeat (100) @(negedge clk);
        chk(wq.size() == 0, "R9 buffers untouched", wq.size(), 0);
    endtask

    task automatic t_ovf();
        int outs[NCH];
        clear_q();
        set_coarse(16'h0100, 16'h0);
        for (int c = 0; c < NCH; c++) fine_in[c*8 +: 8] = 8'(c);
        for (int k = 0; k < 40; k++) begin
            pulse('1);
            repeat (3) @(negedge clk);
        end
        repeat (2500) @(negedge clk);
        for (int c = 0; c < NCH; c++) outs[c] = 0;
        for (int k = 0; k < wq.size(); k += 2) outs[wq[k][15:12]]++;
        check_bursts("R4 R5 burst timing (load)");
        for (int c = 0; c < NCH; c++) begin
            chk(int'(ovf_count[c*OW +: OW]) == 40 - outs[c], "R7 drop count",
                ovf_count[c*OW +: OW], 40 - outs[c]);
        end
        for (int k = 0; k < 600; k++) begin
            pulse('1);
            repeat (3) @(negedge clk);
        end
        repeat (2500) @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            chk(ovf_count[c*OW +: OW] == 8'hFF, "R7 saturation", ovf_count[c*OW +: OW], 8'hFF);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_format();
        t_gray();
        t_dead();
        t_order();
        t_test();
        t_ovf();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule